// File: doc/BRIEF.md
# Block-Paced Graphics Port Data-Phase Engine

This block is the target side of the data phase on a 32-bit graphics port that runs with one data phase per clock. A local request queue hands it one transaction at a time: a direction and a length in bytes. The engine then pulls read words from a local buffer and presents them on the port, or it takes write words and their byte enables from the port and stores them in the buffer. It signals the end of each transaction to the queue with a one-cycle pulse.

Flow control works in blocks of 32 bytes, which is eight words, not in single data phases. The target commits one block at a time by pulling its active-low ready strobe low. It does this only when the buffer can source or sink the whole block. Once the strobe is low, it stays low until every word of that block has moved. The target releases the strobe between blocks. A transaction of 32 bytes or less is covered by a single commit. A length that is not a whole number of blocks ends with a shorter block, and that block follows the same rules.

The master owns the active-low initiator-ready strobe. It may hold it off only at block boundaries. On a write, once it asserts the strobe it keeps it asserted until the end. On a read, it cannot stall the first block.

Top module: `gfx_blk_dphase`

## Requirements
- R1: A synchronous active-high reset puts the engine in idle: `tgt_rdy_n` high, `req_ready` high, `done` low, and neither `rd_pop` nor `wr_push` asserted.
- R2: In idle, a request is taken on a rising edge with `req_valid` high. `req_write` set to 1 means write and 0 means read. The word count is `req_len` divided by four, and the low two bits of the length are dropped.
- R3: A data phase happens on a rising edge only when `tgt_rdy_n` and `mst_rdy_n` are both low. Each such edge moves exactly one word, flagged by `rd_pop` on reads or `wr_push` on writes. While the master holds off, the remaining count does not change.
- R4: The target pulls `tgt_rdy_n` low for a block only after sampling, on the previous edge, a buffer level at least equal to the block size. The level is `rd_avail` for reads and `wr_free` for writes. The block size is the smaller of eight and the words still remaining.
- R5: Once `tgt_rdy_n` is low, it stays low until all words of the committed block have transferred. A master hold-off inside a block only pauses the transfer.
- R6: After the last word of a block, `tgt_rdy_n` goes high for at least one cycle. A transaction of N words therefore takes ceil(N/8) target commits, which is exactly one when N ≤ 8.
- R7: On a read data phase, `rd_data` equals `rd_word`. `wr_data` and `wr_be_n` have no effect: `wr_push` stays low and `wr_be` reads 0.
- R8: On a write data phase, `wr_word` equals `wr_data` and `wr_be` equals the bitwise inverse of `wr_be_n`.
- R9: `done` is high for one cycle, in the cycle after the final data phase. In that cycle `tgt_rdy_n` and `req_ready` are both high.
- R10: A request of fewer than four bytes never pulls `tgt_rdy_n` low. It raises `done` in the cycle after it is accepted.
- R11: When the word count is not a multiple of eight, the final block holds only the leftover words. It is committed against that smaller level and releases after those words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request queue offers a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Transaction length in bytes |
| req_ready | output | 1 | Engine idle, request is taken |
| done | output | 1 | One-cycle end-of-transaction pulse |
| tgt_rdy_n | output | 1 | Target ready strobe, active low |
| mst_rdy_n | input | 1 | Initiator ready strobe, active low |
| rd_data | output | DATA_W | Read data driven onto the port |
| wr_data | input | DATA_W | Write data from the port |
| wr_be_n | input | DATA_W/8 | Write byte enables, active low |
| rd_avail | input | LVL_W | Words held in the read buffer |
| rd_word | input | DATA_W | Head word of the read buffer |
| rd_pop | output | 1 | Consume the read buffer head |
| wr_free | input | LVL_W | Free entries in the write buffer |
| wr_word | output | DATA_W | Word to store in the write buffer |
| wr_be | output | DATA_W/8 | Active-high byte enables stored with the word |
| wr_push | output | 1 | Store into the write buffer |

## Verification
The bench targets the buffer threshold with buffer levels that start empty and refill slowly. An engine that committed early would show a level below the block size at its commit. The master holds off at the start of write blocks and between read blocks. A target that advanced without the master, or dropped its strobe inside a block, would show up as wrong word counts or strobe edges. Lengths of 0, 2, 32, 36, 37 and 256 bytes probe the empty request, the single-commit case, the short tail block and the dropped low length bits. Each of these would give a wrong commit count or a misplaced `done` pulse if handled wrongly.

// File: rtl/gfx_blk_dphase.sv
module gfx_blk_dphase #(
  parameter int LEN_W     = 12,
  parameter int LVL_W     = 6,
  parameter int DATA_W    = 32,
  parameter int BLK_BYTES = 32
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  req_ready,
  output logic                  done,
  output logic                  tgt_rdy_n,
  input  logic                  mst_rdy_n,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W/8-1:0]   wr_be_n,
  input  logic [LVL_W-1:0]      rd_avail,
  input  logic [DATA_W-1:0]     rd_word,
  output logic                  rd_pop,
  input  logic [LVL_W-1:0]      wr_free,
  output logic [DATA_W-1:0]     wr_word,
  output logic [DATA_W/8-1:0]   wr_be,
  output logic                  wr_push
);
  localparam int BE_W      = DATA_W / 8;
  localparam int SHIFT     = $clog2(BE_W);
  localparam int WORD_W    = LEN_W - SHIFT;
  localparam int BLK_WORDS = BLK_BYTES / BE_W;
  localparam int BLK_W     = $clog2(BLK_WORDS + 1);
  localparam int CMP_W     = (LVL_W > WORD_W) ? LVL_W : WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER} st_t;

  st_t               st;
  logic              is_wr;
  logic [WORD_W-1:0] words_left;
  logic [BLK_W-1:0]  blk_left;
  logic [WORD_W-1:0] req_words;
  logic [WORD_W-1:0] need;
  logic [LVL_W-1:0]  level;
  logic              room_ok;
  logic              xfer;

  assign req_words = WORD_W'(req_len >> SHIFT);
  assign need      = (words_left < WORD_W'(BLK_WORDS)) ? words_left : WORD_W'(BLK_WORDS);
  assign level     = is_wr ? wr_free : rd_avail;
  assign room_ok   = CMP_W'(level) >= CMP_W'(need);
  assign xfer      = (st == S_XFER) && !mst_rdy_n;

  assign req_ready = (st == S_IDLE);
  assign tgt_rdy_n = (st != S_XFER);
  assign rd_pop    = xfer && !is_wr;
  assign wr_push   = xfer && is_wr;
  assign rd_data   = (st == S_XFER && !is_wr) ? rd_word : '0;
  assign wr_word   = wr_data;
  assign wr_be     = wr_push ? ~wr_be_n : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      is_wr      <= 1'b0;
      words_left <= '0;
      blk_left   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr      <= req_write;
          words_left <= req_words;
          if (req_words == '0) done <= 1'b1;
          else                 st   <= S_GAP;
        end
        S_GAP: if (room_ok) begin
          st       <= S_XFER;
          blk_left <= BLK_W'(need);
        end
        S_XFER: if (xfer) begin
          words_left <= words_left - 1'b1;
          blk_left   <= blk_left - 1'b1;
          if (blk_left == BLK_W'(1)) begin
            if (words_left == WORD_W'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_GAP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfx_blk_dphase_chk.sv
module gfx_blk_dphase_chk #(
  parameter int LEN_W     = 12,
  parameter int LVL_W     = 6,
  parameter int DATA_W    = 32,
  parameter int BLK_BYTES = 32
)(
  input logic                          clk,
  input logic                          rst,
  input logic                          tgt_rdy_n,
  input logic                          mst_rdy_n,
  input logic                          req_ready,
  input logic                          done,
  input logic                          rd_pop,
  input logic                          wr_push,
  input logic [DATA_W/8-1:0]           wr_be,
  input logic [LVL_W-1:0]              rd_avail,
  input logic [LVL_W-1:0]              wr_free,
  input logic                          is_wr,
  input logic [LEN_W-$clog2(DATA_W/8)-1:0] words_left,
  input logic [$clog2(BLK_BYTES/(DATA_W/8)+1)-1:0] blk_left
);
  localparam int BLK_WORDS = BLK_BYTES / (DATA_W / 8);

  AST_COMMIT_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_rdy_n) |->
      (($past(is_wr) ? int'($past(wr_free)) : int'($past(rd_avail))) >=
       ((int'($past(words_left)) < BLK_WORDS) ? int'($past(words_left)) : BLK_WORDS))); // R4

  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!tgt_rdy_n && (mst_rdy_n || blk_left != 1)) |=> !tgt_rdy_n); // R5

  AST_GAP_AFTER_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!tgt_rdy_n && !mst_rdy_n && blk_left == 1) |=> tgt_rdy_n); // R6

  AST_PHASE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (rd_pop || wr_push) |-> (!tgt_rdy_n && !mst_rdy_n)); // R3

  AST_HOLDOFF_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!tgt_rdy_n && mst_rdy_n) |=> $stable(words_left)); // R3

  AST_READ_NO_BE: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> (wr_be == '0 && !wr_push)); // R7

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (tgt_rdy_n && req_ready)); // R9
endmodule

bind gfx_blk_dphase gfx_blk_dphase_chk #(
  .LEN_W(LEN_W), .LVL_W(LVL_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)
) chk_i (.*);

// File: tb/gfx_blk_dphase_tb_top.sv
`timescale 1ns/1ps
module gfx_blk_dphase_tb_top;
  localparam int LEN_W = 12, LVL_W = 6, DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, done, tgt_rdy_n, rd_pop, wr_push;
  logic mst_rdy_n = 1'b1;
  logic [DATA_W-1:0] rd_data, wr_word;
  logic [DATA_W-1:0] wr_data = '0, rd_word = '0;
  logic [3:0] wr_be_n = '0;
  logic [3:0] wr_be;
  logic [LVL_W-1:0] rd_avail = '0, wr_free = '0;

  int checks = 0, fails = 0;
  int lvl_rd = 0, lvl_wr = 0, rd_idx = 0, wr_idx = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gfx_blk_dphase dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_len(req_len),
    .req_ready(req_ready), .done(done), .tgt_rdy_n(tgt_rdy_n), .mst_rdy_n(mst_rdy_n),
    .rd_data(rd_data), .wr_data(wr_data), .wr_be_n(wr_be_n), .rd_avail(rd_avail),
    .rd_word(rd_word), .rd_pop(rd_pop), .wr_free(wr_free), .wr_word(wr_word),
    .wr_be(wr_be), .wr_push(wr_push)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] pat(int i);
    return {16'hC0DE, i[15:0]} ^ (32'(i) << 20);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_tx(bit w, int len);
    int words = len / 4;
    int done_w = 0, blk_x = 0, blk_need = 0, commits = 0, stall = 0, cyc = 0, commit_lvl = 0;
    bit prev_trdy = 1, got_done = 0, last_prev = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_len = LEN_W'(len);
    stall = w ? $urandom_range(0, 6) : 0;
    mst_rdy_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_done && cyc < 3000) begin
      cyc++;
      if ($urandom_range(0, 2) == 0) lvl_rd = imin(lvl_rd + $urandom_range(1, 4), 16);
      if ($urandom_range(0, 2) == 0) lvl_wr = imin(lvl_wr + $urandom_range(1, 4), 16);
      rd_avail = LVL_W'(lvl_rd < 0 ? 0 : lvl_rd);
      wr_free  = LVL_W'(lvl_wr < 0 ? 0 : lvl_wr);
      mst_rdy_n = (stall > 0);
      if (stall > 0) stall--;
      rd_word = pat(rd_idx);
      wr_data = pat(wr_idx + 32'h8000);
      wr_be_n = 4'($urandom);
      #1;
      if (done) begin
        got_done = 1;
        chk(done_w == words, "R9", "words before done", done_w, words);
        chk(last_prev || words == 0, "R9", "done one cycle after last phase", 0, 1);
        chk(tgt_rdy_n && req_ready, "R9", "strobe/idle at done", {tgt_rdy_n, req_ready}, 2'b11);
        if (words == 0) chk(commits == 0, "R10", "commits on empty request", commits, 0);
      end else if (last_prev) begin
        chk(0, "R9", "done missing after last phase", 0, 1);
      end
      last_prev = 0;
      if (!prev_trdy)
        chk(tgt_rdy_n == (blk_x == blk_need), "R5", "strobe vs block progress", tgt_rdy_n, blk_x == blk_need);
      if (prev_trdy && !tgt_rdy_n) begin
        blk_need = imin(8, words - done_w);
        blk_x = 0;
        commits++;
        chk(commit_lvl >= blk_need, "R4", "level at commit", commit_lvl, blk_need);
        if (blk_need < 8) chk(words % 8 == blk_need, "R11", "tail block size", blk_need, words % 8);
      end
      if (tgt_rdy_n) commit_lvl = w ? lvl_wr : lvl_rd;
      if (!tgt_rdy_n && !mst_rdy_n) begin
        if (w) begin
          chk(wr_push && !rd_pop, "R3", "write phase flags", {wr_push, rd_pop}, 2'b10);
          chk(wr_word == wr_data, "R8", "write word", wr_word, wr_data);
          chk(wr_be == ~wr_be_n, "R8", "byte enables", wr_be, ~wr_be_n);
          wr_idx++; lvl_wr--;
        end else begin
          chk(rd_pop && !wr_push, "R3", "read phase flags", {rd_pop, wr_push}, 2'b10);
          chk(rd_data == pat(rd_idx), "R7", "read word", rd_data, pat(rd_idx));
          chk(wr_be == 4'h0, "R7", "byte enables on read", wr_be, 0);
          rd_idx++; lvl_rd--;
        end
        done_w++; blk_x++;
        if (blk_x == blk_need) begin
          if (done_w == words) last_prev = 1;
          else if (!w) stall = $urandom_range(0, 3);
        end
      end else begin
        chk(!rd_pop && !wr_push, "R3", "no phase without both strobes", {rd_pop, wr_push}, 0);
      end
      if (!tgt_rdy_n && mst_rdy_n && (blk_x > 0 || (!w && done_w < 8 && done_w > 0)))
        chk(0, "R5", "protocol: master stall inside block", 1, 0);
      prev_trdy = tgt_rdy_n;
      @(negedge clk);
    end
    chk(got_done, "R9", "transaction finished", got_done, 1);
    chk(commits == (words + 7) / 8, "R6", "commit count", commits, (words + 7) / 8);
    chk(done_w == words, "R2", "word count from length", done_w, words);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd4177));
    req_valid = 1'b1; req_len = 12'd64;
    repeat (5) @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;
    #1;
    chk(tgt_rdy_n && req_ready && !done && !rd_pop && !wr_push, "R1", "reset state",
        {tgt_rdy_n, req_ready, done, rd_pop, wr_push}, 5'b11000);
    @(negedge clk);
    run_tx(0, 0);    // R10
    run_tx(1, 2);    // R10, R2
    run_tx(0, 32);   // R6 single commit
    run_tx(1, 32);
    run_tx(0, 36);   // R11
    run_tx(1, 37);   // R2, R11
    run_tx(0, 256);
    run_tx(1, 256);
    for (int i = 0; i < 40; i++) run_tx($urandom_range(0, 1), $urandom_range(0, 300));
    report();
  end
endmodule